// File: doc/BRIEF.md
# Multi-Mode 8-bit Timer with Waveform Output

This block is an 8-bit counter with one compare channel and one waveform pin. It runs in one of four modes: a free-running up-counter, a counter that clears after it matches the compare value, a single-slope fast PWM generator, and a dual-slope phase-correct PWM generator. The counting rate comes from a clock select. It can stop the counter, divide the system clock by 1, 8, 64, 256 or 1024, or count synchronized edges of an external pin.

A host writes the counter, the compare value and a configuration word. The configuration word holds the mode, the output action and the clock select. The host can also pulse a force-compare strobe and clear either status flag by writing a one to it. An overflow flag and a compare flag report timer events. In the PWM modes the compare value is double buffered, so a new duty cycle takes effect only at the top of a period.

Top module: `pwm_timer8`

## Requirements
- R1: After reset the counter is 0, both flags are 0 and the waveform output is 0. While the clock select is 0 (stopped), the counter holds its value.
- R2: Clock select codes 1 to 5 advance the counter once every 1, 8, 64, 256 and 1024 system clocks. Code 0 stops the counter.
- R3: Clock select 7 counts rising edges of `ext_pin` and code 6 counts falling edges; an edge of the other polarity has no effect. A pin change made between two clock edges shows on `count` after the third following clock edge, and not after the second.
- R4: In mode 0 (free running) the counter only increments. It wraps from 255 to 0, and `ovf_flag` sets on the same edge as the wrap.
- R5: In mode 1 (clear on compare) a timer tick that finds the counter equal to the compare value loads 0 and sets `cmp_flag` on that edge. With action 1 (toggle) the output inverts on every match, giving a period of 2×(compare+1) ticks.
- R6: In mode 2 (fast PWM) the counter runs 0 to 255. The tick at 255 wraps it to 0 and sets `ovf_flag`. With action 2 (non-inverting) the output goes high on the wrap and low on the tick that finds a match. The wrap wins over a match, so a compare of 255 gives a constant high output and a compare of 0 gives a high pulse one tick wide.
- R7: In mode 3 (phase correct) the counter runs 0 up to 255 and then back down to 0, with 255 and 0 each held for one tick. With action 2, a match while counting up drives the output low and a match while counting down drives it high. `ovf_flag` sets on the tick that leaves 0 after counting down.
- R8: In modes 2 and 3 a compare write goes to a buffer, which is copied into use on the tick at 255 (TOP). In modes 0 and 1 a compare write is used at once.
- R9: A counter write suppresses the compare match of the next timer tick, even when the written value equals the compare value.
- R10: In modes 0 and 1, a `force_cmp` pulse applies the output action (1 toggle, 2 clear, 3 set, 0 none) without setting `cmp_flag` and without changing the counter. In modes 2 and 3 the pulse has no effect on the output.
- R11: Both flags stay set until cleared by a one on `flag_clr` (bit 0 clears overflow, bit 1 clears compare). When a flag is set and cleared on the same edge, the set takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load the configuration fields |
| cfg_mode | input | 2 | Mode: 0 free, 1 clear on compare, 2 fast PWM, 3 phase correct |
| cfg_act | input | 2 | Output action: 0 none, 1 toggle, 2 clear/non-inverting, 3 set/inverting |
| cfg_clk | input | 3 | Clock select: 0 stop, 1..5 divide 1/8/64/256/1024, 6 pin fall, 7 pin rise |
| cnt_wr | input | 1 | Write the counter |
| cnt_wdata | input | 8 | Counter write value |
| cmp_wr | input | 1 | Write the compare value |
| cmp_wdata | input | 8 | Compare write value |
| force_cmp | input | 1 | Force-compare strobe |
| flag_clr | input | 2 | Write-one-to-clear for overflow (bit 0) and compare (bit 1) |
| ext_pin | input | 1 | External count input, asynchronous |
| count | output | 8 | Current counter value |
| wave_out | output | 1 | Waveform output, registered |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare flag |

## Verification
On every cycle, the assertions check these properties:
- The counter holds when there is no tick.
- The wrap in free-running mode raises the overflow flag.
- A match in clear-on-compare mode zeroes the counter.
- The dual-slope counter turns at 255.
- A blocked tick never raises the compare flag.
- A write-one clear takes a flag down.
- A force strobe cannot move the output in a PWM mode.

Only the bench scenarios can show the rest. This covers exact prescaler periods and the three-edge latency of the external pin. It also covers the instant a double-buffered compare value takes hold, the full duty-cycle shapes at compare values 0 and 255, and the turning points of the phase-correct waveform.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_CTC  = 2'd1,
    MODE_FAST = 2'd2,
    MODE_DUAL = 2'd3
  } tmr_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_CLEAR  = 2'd2,
    ACT_SET    = 2'd3
  } tmr_act_e;

  localparam logic [2:0] CS_STOP     = 3'd0;
  localparam logic [2:0] CS_DIV1     = 3'd1;
  localparam logic [2:0] CS_DIV8     = 3'd2;
  localparam logic [2:0] CS_DIV64    = 3'd3;
  localparam logic [2:0] CS_DIV256   = 3'd4;
  localparam logic [2:0] CS_DIV1024  = 3'd5;
  localparam logic [2:0] CS_EXT_FALL = 3'd6;
  localparam logic [2:0] CS_EXT_RISE = 3'd7;
endpackage

// File: rtl/tmr_clksel.sv
`timescale 1ns/1ps
module tmr_clksel
  import tmr_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  input  logic       ext_pin,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [1:0]       sync_q;
  logic             prev_q;
  int               shamt;
  logic [PRE_W-1:0] mask;
  logic             div_hit;
  logic             ext_rise;
  logic             ext_fall;

  // free-running prescaler and pin synchronizer
  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      pre_q  <= pre_q + 1'b1;
      sync_q <= {sync_q[0], ext_pin};
      prev_q <= sync_q[1];
    end
  end

  always_comb begin
    case (sel)
      CS_DIV8:    shamt = 3;
      CS_DIV64:   shamt = 6;
      CS_DIV256:  shamt = 8;
      CS_DIV1024: shamt = 10;
      default:    shamt = 0;
    endcase
  end

  assign mask     = PRE_W'((32'd1 << shamt) - 32'd1);
  assign div_hit  = &(pre_q | ~mask);
  assign ext_rise = sync_q[1] & ~prev_q;
  assign ext_fall = ~sync_q[1] & prev_q;

  always_comb begin
    case (sel)
      CS_STOP:     tick = 1'b0;
      CS_EXT_FALL: tick = ext_fall;
      CS_EXT_RISE: tick = ext_rise;
      default:     tick = div_hit;
    endcase
  end
endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  tmr_mode_e    mode,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic [1:0]   flag_clr,
  output logic [W-1:0] count,
  output logic         dir_down,
  output logic         match_evt,
  output logic         top_wrap,
  output logic         ovf_flag,
  output logic         cmp_flag
);
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] BOT = '0;

  logic [W-1:0] cnt_q, cnt_d, ocr_buf_q, ocr_act_q, ocr_new;
  logic         down_q, down_d, blk_q;
  logic         step, at_top, at_bot, is_pwm, ovf_evt, load_evt;
  logic         ovf_q, cmp_q;

  assign step      = tick && !cnt_wr;
  assign at_top    = (cnt_q == TOP);
  assign at_bot    = (cnt_q == BOT);
  assign is_pwm    = (mode == MODE_FAST) || (mode == MODE_DUAL);
  assign match_evt = step && !blk_q && (cnt_q == ocr_act_q);
  assign top_wrap  = step && at_top && (mode != MODE_DUAL);
  assign ocr_new   = cmp_wr ? cmp_wdata : ocr_buf_q;

  always_comb begin
    cnt_d    = cnt_q;
    down_d   = (mode == MODE_DUAL) ? down_q : 1'b0;
    ovf_evt  = 1'b0;
    load_evt = 1'b0;
    if (cnt_wr) begin
      cnt_d = cnt_wdata;
    end else if (tick) begin
      case (mode)
        MODE_FREE: begin
          cnt_d   = cnt_q + 1'b1;
          ovf_evt = at_top;
        end
        MODE_CTC: begin
          cnt_d   = match_evt ? BOT : cnt_q + 1'b1;
          ovf_evt = at_top;
        end
        MODE_FAST: begin
          cnt_d    = cnt_q + 1'b1;
          ovf_evt  = at_top;
          load_evt = at_top;
        end
        default: begin
          if (!down_q) begin
            if (at_top) begin
              down_d   = 1'b1;
              cnt_d    = TOP - 1'b1;
              load_evt = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else begin
            if (at_bot) begin
              down_d  = 1'b0;
              cnt_d   = BOT + 1'b1;
              ovf_evt = 1'b1;
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      down_q    <= 1'b0;
      blk_q     <= 1'b0;
      ocr_buf_q <= '0;
      ocr_act_q <= '0;
      ovf_q     <= 1'b0;
      cmp_q     <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
      if (cnt_wr)    blk_q <= 1'b1;
      else if (tick) blk_q <= 1'b0;
      if (cmp_wr) ocr_buf_q <= cmp_wdata;
      if (!is_pwm || load_evt) ocr_act_q <= ocr_new;
      ovf_q <= ovf_evt   | (ovf_q & ~flag_clr[0]);
      cmp_q <= match_evt | (cmp_q & ~flag_clr[1]);
    end
  end

  assign count    = cnt_q;
  assign dir_down = down_q;
  assign ovf_flag = ovf_q;
  assign cmp_flag = cmp_q;

  // R1
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cnt_wr) |=> $stable(cnt_q));
  // R4
  free_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (step && mode == MODE_FREE && at_top) |=> (cnt_q == BOT && ovf_q));
  // R5
  ctc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (match_evt && mode == MODE_CTC) |=> (cnt_q == BOT && cmp_q));
  // R7
  dual_turn_chk: assert property (@(posedge clk) disable iff (rst)
    (step && mode == MODE_DUAL && at_top && !down_q) |=> (cnt_q == TOP - 1'b1 && down_q));
  // R9
  blocked_match_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && blk_q && !cmp_q) |=> !cmp_q);
  // R11
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_clr[0] && !ovf_evt) |=> !ovf_q);
endmodule

// File: rtl/tmr_wave.sv
`timescale 1ns/1ps
module tmr_wave
  import tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  tmr_mode_e mode,
  input  tmr_act_e  act,
  input  logic      force_cmp,
  input  logic      match_evt,
  input  logic      top_wrap,
  input  logic      dir_down,
  output logic      wave
);
  logic wave_q, wave_d;

  always_comb begin
    wave_d = wave_q;
    case (mode)
      MODE_FAST: begin
        if (act == ACT_CLEAR) begin
          if (top_wrap)       wave_d = 1'b1;
          else if (match_evt) wave_d = 1'b0;
        end else if (act == ACT_SET) begin
          if (top_wrap)       wave_d = 1'b0;
          else if (match_evt) wave_d = 1'b1;
        end
      end
      MODE_DUAL: begin
        if (match_evt) begin
          if (act == ACT_CLEAR)    wave_d = dir_down;
          else if (act == ACT_SET) wave_d = !dir_down;
        end
      end
      default: begin
        if (match_evt || force_cmp) begin
          case (act)
            ACT_TOGGLE: wave_d = !wave_q;
            ACT_CLEAR:  wave_d = 1'b0;
            ACT_SET:    wave_d = 1'b1;
            default:    wave_d = wave_q;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) wave_q <= 1'b0;
    else     wave_q <= wave_d;
  end

  assign wave = wave_q;

  // R10
  pwm_force_chk: assert property (@(posedge clk) disable iff (rst)
    (force_cmp && (mode == MODE_FAST || mode == MODE_DUAL) && !match_evt && !top_wrap)
      |=> $stable(wave_q));
  // R6
  fast_bottom_chk: assert property (@(posedge clk) disable iff (rst)
    (top_wrap && mode == MODE_FAST && act == ACT_CLEAR) |=> wave_q);
endmodule

// File: rtl/pwm_timer8.sv
`timescale 1ns/1ps
module pwm_timer8
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_mode,
  input  logic [1:0]       cfg_act,
  input  logic [2:0]       cfg_clk,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             force_cmp,
  input  logic [1:0]       flag_clr,
  input  logic             ext_pin,
  output logic [CNT_W-1:0] count,
  output logic             wave_out,
  output logic             ovf_flag,
  output logic             cmp_flag
);
  tmr_mode_e mode_q;
  tmr_act_e  act_q;
  logic [2:0] sel_q;
  logic tick, match_evt, top_wrap, dir_down;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_FREE;
      act_q  <= ACT_NONE;
      sel_q  <= CS_STOP;
    end else if (cfg_wr) begin
      mode_q <= tmr_mode_e'(cfg_mode);
      act_q  <= tmr_act_e'(cfg_act);
      sel_q  <= cfg_clk;
    end
  end

  tmr_clksel #(.PRE_W(PRE_W)) u_clksel (
    .clk(clk), .rst(rst), .sel(sel_q), .ext_pin(ext_pin), .tick(tick)
  );

  tmr_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode_q),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .flag_clr(flag_clr),
    .count(count), .dir_down(dir_down), .match_evt(match_evt),
    .top_wrap(top_wrap), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );

  tmr_wave u_wave (
    .clk(clk), .rst(rst), .mode(mode_q), .act(act_q), .force_cmp(force_cmp),
    .match_evt(match_evt), .top_wrap(top_wrap), .dir_down(dir_down),
    .wave(wave_out)
  );
endmodule

// File: tb/pwm_timer8_bench.sv
`timescale 1ns/1ps
module pwm_timer8_bench;
  localparam logic [1:0] M_FREE = 2'd0, M_CTC = 2'd1, M_FAST = 2'd2, M_DUAL = 2'd3;
  localparam logic [1:0] A_NONE = 2'd0, A_TOG = 2'd1, A_CLR = 2'd2, A_SET = 2'd3;
  localparam logic [2:0] C_STOP = 3'd0, C_D1 = 3'd1, C_D8 = 3'd2, C_D64 = 3'd3,
                         C_D1024 = 3'd5, C_EF = 3'd6, C_ER = 3'd7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_mode = '0;
  logic [1:0] cfg_act = '0;
  logic [2:0] cfg_clk = '0;
  logic       cnt_wr = 1'b0;
  logic [7:0] cnt_wdata = '0;
  logic       cmp_wr = 1'b0;
  logic [7:0] cmp_wdata = '0;
  logic       force_cmp = 1'b0;
  logic [1:0] flag_clr = '0;
  logic       ext_pin = 1'b0;
  logic [7:0] count;
  logic       wave_out, ovf_flag, cmp_flag;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pwm_timer8 u_pwm_timer8 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_act(cfg_act),
    .cfg_clk(cfg_clk), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cmp_wr(cmp_wr),
    .cmp_wdata(cmp_wdata), .force_cmp(force_cmp), .flag_clr(flag_clr),
    .ext_pin(ext_pin), .count(count), .wave_out(wave_out), .ovf_flag(ovf_flag),
    .cmp_flag(cmp_flag)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [1:0] m, input logic [1:0] a, input logic [2:0] c);
    cfg_mode = m; cfg_act = a; cfg_clk = c; cfg_wr = 1'b1;
    step(1);
    cfg_wr = 1'b0;
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    cnt_wdata = v; cnt_wr = 1'b1;
    step(1);
    cnt_wr = 1'b0;
  endtask

  task automatic wr_cmp(input logic [7:0] v);
    cmp_wdata = v; cmp_wr = 1'b1;
    step(1);
    cmp_wr = 1'b0;
  endtask

  task automatic clr_flags(input logic [1:0] v);
    flag_clr = v;
    step(1);
    flag_clr = '0;
  endtask

  task automatic pulse_force();
    force_cmp = 1'b1;
    step(1);
    force_cmp = 1'b0;
  endtask

  task automatic setup(input logic [1:0] m, input logic [1:0] a, input logic [7:0] ocr,
                       input logic [7:0] cnt, input logic [2:0] c);
    wr_cfg(M_FREE, a, C_STOP);
    wr_cmp(ocr);
    wr_cnt(cnt);
    clr_flags(2'b11);
    wr_cfg(m, a, c);
  endtask

  task automatic test_reset();
    chk("R1", "count after reset", count, 0);
    chk("R1", "wave after reset", wave_out, 0);
    chk("R1", "ovf after reset", ovf_flag, 0);
    chk("R1", "cmp after reset", cmp_flag, 0);
    step(20);
    chk("R1", "count with stopped clock", count, 0);
  endtask

  task automatic test_free();
    setup(M_FREE, A_NONE, 8'd0, 8'd250, C_D1);
    step(5);
    chk("R4", "count before wrap", count, 255);
    chk("R4", "ovf before wrap", ovf_flag, 0);
    step(1);
    chk("R4", "count after wrap", count, 0);
    chk("R4", "ovf after wrap", ovf_flag, 1);
  endtask

  task automatic test_ctc();
    logic w0;
    setup(M_CTC, A_TOG, 8'd5, 8'd0, C_D1);
    w0 = wave_out;
    step(5);
    chk("R5", "count at compare", count, 5);
    chk("R5", "cmp before match tick", cmp_flag, 0);
    step(1);
    chk("R5", "count cleared", count, 0);
    chk("R5", "cmp after match", cmp_flag, 1);
    chk("R5", "wave toggled", wave_out, int'(!w0));
    step(6);
    chk("R5", "wave toggled back", wave_out, int'(w0));
  endtask

  task automatic test_block();
    setup(M_CTC, A_NONE, 8'd7, 8'd7, C_D1);
    step(1);
    chk("R9", "count passes blocked match", count, 8);
    chk("R9", "cmp stays clear", cmp_flag, 0);
    step(255);
    chk("R9", "count back at compare", count, 7);
    step(1);
    chk("R9", "unblocked match clears", count, 0);
    chk("R9", "unblocked match flags", cmp_flag, 1);
  endtask

  task automatic test_force();
    setup(M_CTC, A_SET, 8'd200, 8'd0, C_STOP);
    pulse_force();
    chk("R10", "force set", wave_out, 1);
    chk("R10", "force no flag", cmp_flag, 0);
    chk("R10", "force keeps count", count, 0);
    wr_cfg(M_CTC, A_CLR, C_STOP);
    pulse_force();
    chk("R10", "force clear", wave_out, 0);
    wr_cfg(M_CTC, A_SET, C_STOP);
    pulse_force();
    wr_cfg(M_FAST, A_CLR, C_STOP);
    pulse_force();
    chk("R10", "force ignored in PWM", wave_out, 1);
  endtask

  task automatic test_flags();
    setup(M_FREE, A_NONE, 8'd2, 8'd254, C_D1);
    step(3);
    chk("R11", "ovf set", ovf_flag, 1);
    chk("R11", "cmp not yet", cmp_flag, 0);
    step(2);
    chk("R11", "cmp set", cmp_flag, 1);
    wr_cfg(M_FREE, A_NONE, C_STOP);
    clr_flags(2'b01);
    chk("R11", "ovf cleared", ovf_flag, 0);
    chk("R11", "cmp sticky", cmp_flag, 1);
    clr_flags(2'b10);
    chk("R11", "cmp cleared", cmp_flag, 0);
  endtask

  task automatic test_fast();
    int bad;
    setup(M_FAST, A_CLR, 8'd3, 8'd0, C_D1);
    step(4);
    chk("R6", "low after match", wave_out, 0);
    step(251);
    chk("R6", "count at top", count, 255);
    chk("R6", "ovf not yet", ovf_flag, 0);
    step(1);
    chk("R6", "wrap count", count, 0);
    chk("R6", "ovf at top", ovf_flag, 1);
    chk("R6", "high at bottom", wave_out, 1);
    step(3);
    chk("R6", "high before match", wave_out, 1);
    step(1);
    chk("R6", "low at match", wave_out, 0);
    wr_cmp(8'd100);
    step(251);
    step(4);
    chk("R8", "old compare no longer used", wave_out, 1);
    step(96);
    chk("R8", "high until new compare", wave_out, 1);
    step(1);
    chk("R8", "new compare takes effect", wave_out, 0);
    wr_cmp(8'd255);
    step(154);
    bad = 0;
    for (int i = 0; i < 256; i++) begin
      step(1);
      if (wave_out !== 1'b1) bad++;
    end
    chk("R6", "compare 255 low samples", bad, 0);
    wr_cmp(8'd0);
    step(255);
    chk("R6", "spike high", wave_out, 1);
    step(1);
    chk("R6", "spike one tick", wave_out, 0);
  endtask

  task automatic test_dual();
    setup(M_DUAL, A_CLR, 8'd10, 8'd0, C_D1);
    step(11);
    chk("R7", "count up", count, 11);
    chk("R7", "low after up match", wave_out, 0);
    step(244);
    chk("R7", "at top", count, 255);
    step(1);
    chk("R7", "turned down", count, 254);
    step(244);
    chk("R7", "down to compare", count, 10);
    chk("R7", "still low", wave_out, 0);
    step(1);
    chk("R7", "high after down match", wave_out, 1);
    step(9);
    chk("R7", "at bottom", count, 0);
    chk("R7", "ovf not yet", ovf_flag, 0);
    step(1);
    chk("R7", "turned up", count, 1);
    chk("R7", "ovf at bottom", ovf_flag, 1);
  endtask

  task automatic measure(input logic [2:0] c, input int div);
    logic [7:0] p;
    int n;
    setup(M_FREE, A_NONE, 8'd0, 8'd0, c);
    p = count;
    n = 0;
    while (count == p && n < 4000) begin step(1); n++; end
    p = count;
    n = 0;
    while (count == p && n < 4000) begin step(1); n++; end
    chk("R2", "prescaler interval", n, div);
  endtask

  task automatic test_ext();
    ext_pin = 1'b0;
    setup(M_FREE, A_NONE, 8'd0, 8'd0, C_ER);
    step(3);
    ext_pin = 1'b1;
    step(2);
    chk("R3", "rise not yet counted", count, 0);
    step(1);
    chk("R3", "rise counted", count, 1);
    wr_cfg(M_FREE, A_NONE, C_EF);
    ext_pin = 1'b0;
    step(2);
    chk("R3", "fall not yet counted", count, 1);
    step(1);
    chk("R3", "fall counted", count, 2);
    ext_pin = 1'b1;
    step(6);
    chk("R3", "rise ignored on fall select", count, 2);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    test_reset();
    test_free();
    test_ctc();
    test_block();
    test_force();
    test_flags();
    test_fast();
    test_dual();
    measure(C_D1, 1);
    measure(C_D8, 8);
    measure(C_D64, 64);
    measure(C_D1024, 1024);
    test_ext();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule